// File: doc/BRIEF.md
# Random Replacement Index Generator

This block picks which entry of a translation lookaside buffer is overwritten on a random refill. The lowest entries of the buffer can be pinned. The caller gives the pinned count (`wired_i`) and the total entry count (`total_i`). The answer always falls between the pinned count and the last entry, and it is never the index handed out the time before.

A 32-bit right-shifting Galois LFSR supplies the randomness and advances once per attempt. Its value is reduced modulo the number of unpinned entries by a serial shift-and-subtract unit, one dividend bit per cycle. The pinned count is then added to the remainder. If the resulting candidate equals the previous answer, the LFSR steps again and the reduction is repeated.

A request is a one-cycle strobe on `req_i`. The block is busy until the result appears with a one-cycle `valid_o` pulse. A configuration in which no fresh index can exist is refused, and `cfg_err_o` flags it.

The controller has five states:

- IDLE waits for a request. An accepted request moves it to STEP.
- STEP advances the LFSR and always moves to LOAD.
- LOAD starts the modulo unit with the new LFSR value and always moves to DIVIDE.
- DIVIDE waits for the remainder. A candidate equal to the last answer sends it back to STEP. Any other candidate moves it to DONE.
- DONE raises `valid_o` for one cycle and always returns to IDLE.

Top module: `repl_index_gen`

## Requirements
- R1: After reset, `idx_o` is 0, `valid_o` is 0 and `busy_o` is 0.
- R2: The LFSR starts at 1. On each attempt it shifts right by one bit, and when the bit shifted out is 1 it is then XORed with 0xD0000001.
- R3: The candidate index is (LFSR value mod (total − wired)) + wired, so every result lies in [wired, total − 1].
- R4: A result never equals the previously returned index. A matching candidate causes another LFSR step and another reduction. `idx_o` changes only on a `valid_o` cycle.
- R5: The remembered previous index is 0 after reset, so the first result cannot be 0.
- R6: An accepted request raises `busy_o` on the next cycle. `valid_o` is a single-cycle pulse, raised while `busy_o` is still 1, and `busy_o` falls on the cycle after the pulse.
- R7: A request seen while `busy_o` is 1 is ignored. It produces no extra result and does not advance the LFSR.
- R8: `cfg_err_o` is 1 exactly when `total_i` ≤ `wired_i` + 1. A request made while it is 1 is ignored, leaving `busy_o` at 0 and the LFSR unchanged.
- R9: `wired_i` and `total_i` are captured when a request is accepted. Changes to them during the computation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request for a new index |
| wired_i | input | IDX_W | Number of pinned low entries |
| total_i | input | IDX_W+1 | Total number of entries |
| busy_o | output | 1 | High from acceptance through the result cycle |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| idx_o | output | IDX_W | Most recent replacement index |
| cfg_err_o | output | 1 | Configuration has no non-repeating index |

## Verification
The bound checker watches every cycle for the following:

- each result lies inside the range captured at acceptance;
- no result repeats the one before it;
- `valid_o` lasts one cycle, inside the busy window;
- accepted requests raise `busy_o`, and refused ones do not;
- `idx_o` moves only on a result.

Only the bench's scoreboard can show that the actual sequence of indices follows the LFSR and modulo rule. This covers the retry path with a two-entry range, the untouched LFSR after ignored requests, and the use of the captured configuration after the inputs change.

// File: rtl/repl_index_pkg.sv
package repl_index_pkg;

    parameter int unsigned LFSR_W = 32;
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'hD000_0001;
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP,
        S_LOAD,
        S_DIVIDE,
        S_DONE
    } rig_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/rig_lfsr.sv
module rig_lfsr
    import repl_index_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LFSR_SEED;
        end else if (step_i) begin
            state_q <= lfsr_advance(state_q);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rig_serial_mod.sv
module rig_serial_mod #(
    parameter int unsigned DW = 32,
    parameter int unsigned MW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dividend_i,
    input  logic [MW-1:0] divisor_i,
    output logic          done_o,
    output logic [MW-1:0] rem_o
);

    localparam int unsigned CW = $clog2(DW + 1);

    logic [DW-1:0] dvd_q;
    logic [MW-1:0] div_q;
    logic [MW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          done_q;
    logic [MW:0]   trial;
    logic [MW:0]   diff;

    assign trial = {rem_q, dvd_q[DW-1]};
    assign diff  = trial - {1'b0, div_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            div_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                dvd_q <= dividend_i;
                div_q <= divisor_i;
                rem_q <= '0;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= (trial >= {1'b0, div_q}) ? diff[MW-1:0] : trial[MW-1:0];
                dvd_q <= dvd_q << 1;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign rem_o  = rem_q;

endmodule

// File: rtl/repl_index_gen.sv
module repl_index_gen
    import repl_index_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IDX_W-1:0] wired_i,
    input  logic [IDX_W:0]   total_i,
    output logic             busy_o,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             cfg_err_o
);

    localparam int unsigned CNT_W = IDX_W + 1;

    rig_state_e        state_q, state_d;
    logic [IDX_W-1:0]  wired_q;
    logic [CNT_W-1:0]  range_q;
    logic [IDX_W-1:0]  last_q;
    logic [LFSR_W-1:0] lfsr_val;
    logic              lfsr_step;
    logic              mod_start;
    logic              mod_done;
    logic [CNT_W-1:0]  mod_rem;
    logic [CNT_W-1:0]  cand;
    logic              cand_rep;
    logic              accept;

    assign cfg_err_o = total_i <= ({1'b0, wired_i} + CNT_W'(1));
    assign accept    = (state_q == S_IDLE) && req_i && !cfg_err_o;
    assign cand      = mod_rem + {1'b0, wired_q};
    assign cand_rep  = cand == {1'b0, last_q};

    rig_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (lfsr_step),
        .state_o (lfsr_val)
    );

    rig_serial_mod #(
        .DW (LFSR_W),
        .MW (CNT_W)
    ) u_mod (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (mod_start),
        .dividend_i (lfsr_val),
        .divisor_i  (range_q),
        .done_o     (mod_done),
        .rem_o      (mod_rem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_STEP;
            S_STEP:   state_d = S_LOAD;
            S_LOAD:   state_d = S_DIVIDE;
            S_DIVIDE: if (mod_done) state_d = cand_rep ? S_STEP : S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // captured configuration and last answer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wired_q <= '0;
            range_q <= '0;
            last_q  <= '0;
        end else begin
            if (accept) begin
                wired_q <= wired_i;
                range_q <= total_i - {1'b0, wired_i};
            end
            if (state_q == S_DIVIDE && mod_done && !cand_rep) begin
                last_q <= cand[IDX_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        lfsr_step = 1'b0;
        mod_start = 1'b0;
        valid_o   = 1'b0;
        busy_o    = 1'b1;
        unique case (state_q)
            S_IDLE:   busy_o    = 1'b0;
            S_STEP:   lfsr_step = 1'b1;
            S_LOAD:   mod_start = 1'b1;
            S_DIVIDE: ;
            S_DONE:   valid_o   = 1'b1;
            default:  busy_o    = 1'b0;
        endcase
    end

    assign idx_o = last_q;

endmodule

// File: rtl/repl_index_gen_chk.sv
module repl_index_gen_chk #(
    parameter int unsigned IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [IDX_W-1:0] wired_i,
    input logic [IDX_W:0]   total_i,
    input logic             busy_o,
    input logic             valid_o,
    input logic [IDX_W-1:0] idx_o,
    input logic             cfg_err_o
);

    logic [IDX_W-1:0] cap_w;
    logic [IDX_W:0]   cap_t;
    logic [IDX_W-1:0] prev_q;
    logic             acc;

    assign acc = req_i && !busy_o && !cfg_err_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_w  <= '0;
            cap_t  <= '0;
            prev_q <= '0;
        end else begin
            if (acc) begin
                cap_w <= wired_i;
                cap_t <= total_i;
            end
            if (valid_o) prev_q <= idx_o;
        end
    end

    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, idx_o} >= {1'b0, cap_w}) && ({1'b0, idx_o} < cap_t));

    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> idx_o != prev_q);

    p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idx_o) |-> $past(valid_o) || valid_o);

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy_o);

    p_err_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o && cfg_err_o) |=> !busy_o);

endmodule

bind repl_index_gen repl_index_gen_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wired_i   (wired_i),
    .total_i   (total_i),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .idx_o     (idx_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/repl_index_gen_test.sv
module repl_index_gen_test;

    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [IDX_W-1:0] wired_i = '0;
    logic [IDX_W:0]   total_i = 7'd16;
    logic             busy_o, valid_o, cfg_err_o;
    logic [IDX_W-1:0] idx_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int idx;
        int w;
        int t;
        int prev;
        int tag5;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_lfsr = 32'd1;
    int          m_last = 0;
    int          first_done = 0;

    always #10 clk = ~clk;

    repl_index_gen #(.IDX_W(IDX_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wired_i   (wired_i),
        .total_i   (total_i),
        .busy_o    (busy_o),
        .valid_o   (valid_o),
        .idx_o     (idx_o),
        .cfg_err_o (cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 / R3 / R4 model
    function automatic exp_t predict(input int w, input int t);
        exp_t e;
        int   cand;
        do begin
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'hD000_0001 : 32'h0);
            cand = int'(m_lfsr % 32'(t - w)) + w;
        end while (cand == m_last);
        e.idx  = cand;
        e.w    = w;
        e.t    = t;
        e.prev = m_last;
        e.tag5 = (first_done == 0) ? 1 : 0;
        first_done = 1;
        m_last = cand;
        return e;
    endfunction

    task automatic send(input int w, input int t);
        while (busy_o) @(negedge clk);
        wired_i = IDX_W'(w);
        total_i = (IDX_W+1)'(t);
        sb.push_back(predict(w, t));
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected result", int'(idx_o), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(idx_o) == e.idx, "R2 R3 index value", int'(idx_o), e.idx);
                check(int'(idx_o) >= e.w && int'(idx_o) < e.t, "R3 range", int'(idx_o), e.w);
                check(int'(idx_o) != e.prev, "R4 no repeat", int'(idx_o), e.prev);
                if (e.tag5 == 1) check(idx_o != 0, "R5 first result non-zero", int'(idx_o), 1);
                check(busy_o == 1'b1, "R6 busy during result", int'(busy_o), 1);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(idx_o == 0, "R1 reset idx", int'(idx_o), 0);
        check(valid_o == 0, "R1 reset valid", int'(valid_o), 0);
        check(busy_o == 0, "R1 reset busy", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 cfg_err decode
        wired_i = 6'd2; total_i = 7'd3; #1;
        check(cfg_err_o == 1, "R8 err t=3 w=2", int'(cfg_err_o), 1);
        wired_i = 6'd2; total_i = 7'd4; #1;
        check(cfg_err_o == 0, "R8 ok t=4 w=2", int'(cfg_err_o), 0);
        wired_i = 6'd5; total_i = 7'd5; #1;
        check(cfg_err_o == 1, "R8 err t=5 w=5", int'(cfg_err_o), 1);
        // request refused under bad config
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check(busy_o == 0, "R8 refused request busy", int'(busy_o), 0);
        repeat (40) @(negedge clk);
        check(busy_o == 0, "R8 still idle", int'(busy_o), 0);

        // R5: two-entry range, first result must be 1
        send(0, 2);
        check(busy_o == 1, "R6 busy after accept", int'(busy_o), 1);
        // R7: request while busy
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        for (int i = 0; i < 12; i++) send(0, 16);
        for (int i = 0; i < 8; i++) send(4, 48);
        for (int i = 0; i < 6; i++) send(8, 64);
        // two-entry range forces retries
        for (int i = 0; i < 8; i++) send(62, 64);
        // R9: inputs change during computation
        for (int i = 0; i < 4; i++) begin
            send(4, 20);
            wired_i = 6'd10;
            total_i = 7'd12;
        end
        // R7 again mid-computation
        send(1, 33);
        repeat (5) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        send(0, 64);

        for (int i = 0; i < 3000 && (sb.size() != 0 || busy_o); i++) @(negedge clk);
        check(sb.size() == 0, "R7 all results seen", sb.size(), 0);
        check(busy_o == 0, "R6 busy drops after result", int'(busy_o), 0);
        finish_run();
    end

endmodule